// File: doc/BRIEF.md
# Guard-Bit Accumulator with Requantizing Output

This block sums a stream of signed fixed-point samples into a register that is wider than the sample by `GUARD` bits, all of them on the integer side. A run starts with a clear pulse. Valid samples are sign-extended and added until the programmed block length has been reached. The wide sum is then reduced to a shorter result word. The `DROP` least significant fraction bits are removed, either by truncation or by round-half-up. The result word keeps the same total width as the input word but has `GUARD` more integer bits, so its binary point sits `GUARD` places further right than the sample's.

With the defaults, a sample is 12 bits, for example four integer bits and eight fraction bits. The accumulator is 16 bits. The result is 12 bits with four fraction bits. Up to 2^GUARD samples add without any chance of wrap. A longer run sets a sticky overflow flag.

Control states:
- `ST_IDLE`: waits for a clear.
- `ST_RUN`: accepts samples.
- `ST_EMIT`: presents the result for one cycle.

Transitions:
- Clear, taken from any state: goes to `ST_RUN`. It goes to `ST_EMIT` instead when the clear carries a sample and the length is one.
- Last sample accepted: `ST_RUN` to `ST_EMIT`.
- Emit done: `ST_EMIT` to `ST_IDLE`.

Top module: `gacc_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, `res_vld` and `ovf` are 0 and the block is idle.
- R2: Each accepted sample is sign-extended to `IN_W+GUARD` bits and added in two's complement, so negative and positive samples sum to their exact value.
- R3: Any run of at most 2^GUARD samples, including all-maximum and all-minimum samples, gives the exact sum, and `ovf` stays 0.
- R4: A clear loads the sample presented with it (`smp_vld` high) or zero (`smp_vld` low) and restarts the sample count. A clear in the middle of a run discards the partial sum.
- R5: `res_vld` is high for exactly one cycle. That cycle follows the clock edge at which the sample that brings the count to `blk_len` is accepted.
- R6: With `rnd_mode`=0, `res_data` is the wide sum shifted right arithmetically by `DROP` bits, which is floor(sum / 2^DROP).
- R7: With `rnd_mode`=1, `res_data` is floor((sum + 2^(DROP-1)) / 2^DROP), which is round half up.
- R8: If rounding carries past the most positive result code (2^(OUT_W-1)-1), `res_data` saturates at that code instead of wrapping negative.
- R9: Accepting more than 2^GUARD samples in one run sets `ovf`. The flag stays set through the result and the idle period, and the next clear resets it.
- R10: A sample with `smp_vld` high is ignored while idle or emitting. It produces no `res_vld` and changes neither `ovf` nor the next run's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Start pulse. Restarts the sum and the count |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | IN_W | Signed input sample |
| blk_len | input | LEN_W | Samples per run, 1 or more, held during a run |
| rnd_mode | input | 1 | 1 = round half up, 0 = truncate |
| res_vld | output | 1 | One-cycle result strobe |
| res_data | output | OUT_W | Signed requantized result, OUT_W = IN_W+GUARD-DROP |
| ovf | output | 1 | Sticky flag: run exceeded 2^GUARD samples |

## Verification
Directed runs cover several cases:
- A mixed-sign pair that needs sign extension to sum correctly.
- Full runs of the largest positive and the most negative sample, which show that the guard bits absorb the worst case exactly.
- Single samples sitting at, just above and just below a half-LSB boundary, which separate truncation from rounding for both signs.

A run one sample longer than the guaranteed count, arranged so that its wrapped sum lands on the top code, exercises the overflow flag and output saturation together. Randomized runs of random length, with random gaps, random rounding mode, and a clear either with or without a sample, are compared against a bench model. Separate runs check a mid-run restart and samples arriving while idle.

// File: rtl/gacc_pkg.sv
package gacc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_EMIT = 2'd2
    } gacc_state_e;
endpackage

// File: rtl/gacc_ctrl.sv
module gacc_ctrl
    import gacc_pkg::*;
#(
    parameter int GUARD = 4,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             smp_vld,
    input  logic [LEN_W-1:0] blk_len,
    output logic             acc_load,
    output logic             acc_add,
    output logic             emit,
    output logic             ovf
);
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(1) << GUARD;

    gacc_state_e      state_q, state_d;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W:0]   cnt_inc;
    logic             hit_end;
    logic             accept;
    logic             ovf_q;

    assign cnt_inc = {1'b0, cnt_q} + (LEN_W+1)'(1);
    assign hit_end = (cnt_inc == {1'b0, blk_len});
    assign accept  = (state_q == ST_RUN) && smp_vld && !clr;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = (smp_vld && blk_len == LEN_W'(1)) ? ST_EMIT : ST_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN:  if (smp_vld && hit_end) state_d = ST_EMIT;
                ST_EMIT: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state, counter and sticky flag registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (clr) begin
                cnt_q <= LEN_W'(smp_vld);
                ovf_q <= 1'b0;
            end else if (accept) begin
                cnt_q <= cnt_inc[LEN_W-1:0];
                if (cnt_q >= LIMIT) ovf_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        acc_load = clr;
        acc_add  = accept;
        emit     = (state_q == ST_EMIT);
        ovf      = ovf_q;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE && !ovf_q));
    a_r4_clr_count: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == LEN_W'($past(smp_vld))));
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (emit && !clr) |=> !emit);
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !clr) |=> ovf_q);
    a_r3_guard_limit: assert property (@(posedge clk) disable iff (rst)
        (cnt_q > LIMIT) |-> ovf_q);
endmodule

// File: rtl/gacc_sum.sv
module gacc_sum #(
    parameter int IN_W  = 12,
    parameter int GUARD = 4,
    localparam int ACC_W = IN_W + GUARD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              add,
    input  logic              smp_vld,
    input  logic [IN_W-1:0]   smp_data,
    output logic [ACC_W-1:0]  acc
);
    logic [ACC_W-1:0] ext;
    logic [ACC_W-1:0] acc_q;

    assign ext = {{GUARD{smp_data[IN_W-1]}}, smp_data};

    always_ff @(posedge clk) begin
        if (rst)       acc_q <= '0;
        else if (load) acc_q <= smp_vld ? ext : '0;
        else if (add)  acc_q <= acc_q + ext;
    end

    assign acc = acc_q;

    a_r10_hold_sum: assert property (@(posedge clk) disable iff (rst)
        (!load && !add) |=> $stable(acc_q));
endmodule

// File: rtl/gacc_requant.sv
module gacc_requant #(
    parameter int ACC_W = 16,
    parameter int DROP  = 4,
    localparam int OUT_W = ACC_W - DROP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rnd_mode,
    input  logic [ACC_W-1:0] acc,
    output logic [OUT_W-1:0] res
);
    localparam logic [OUT_W-1:0] MAX_CODE = {1'b0, {(OUT_W-1){1'b1}}};

    generate
        if (DROP == 0) begin : g_pass
            assign res = acc;
        end else begin : g_shift
            logic [OUT_W-1:0] trunc;
            logic [OUT_W:0]   rnd_wide;
            assign trunc    = acc[ACC_W-1:DROP];
            assign rnd_wide = {trunc[OUT_W-1], trunc} + (OUT_W+1)'(acc[DROP-1]);
            always_comb begin
                if (!rnd_mode)
                    res = trunc;
                else if (rnd_wide[OUT_W] != rnd_wide[OUT_W-1])
                    res = MAX_CODE;
                else
                    res = rnd_wide[OUT_W-1:0];
            end
        end
    endgenerate

    a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !acc[ACC_W-1] |-> !res[OUT_W-1]);
endmodule

// File: rtl/gacc_top.sv
module gacc_top #(
    parameter int IN_W  = 12,
    parameter int GUARD = 4,
    parameter int DROP  = 4,
    parameter int LEN_W = GUARD + 2,
    localparam int ACC_W = IN_W + GUARD,
    localparam int OUT_W = ACC_W - DROP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             smp_vld,
    input  logic [IN_W-1:0]  smp_data,
    input  logic [LEN_W-1:0] blk_len,
    input  logic             rnd_mode,
    output logic             res_vld,
    output logic [OUT_W-1:0] res_data,
    output logic             ovf
);
    logic             acc_load;
    logic             acc_add;
    logic [ACC_W-1:0] acc;

    gacc_ctrl #(.GUARD(GUARD), .LEN_W(LEN_W)) ctrl_i (
        .clk(clk), .rst(rst), .clr(clr), .smp_vld(smp_vld), .blk_len(blk_len),
        .acc_load(acc_load), .acc_add(acc_add), .emit(res_vld), .ovf(ovf)
    );

    gacc_sum #(.IN_W(IN_W), .GUARD(GUARD)) sum_i (
        .clk(clk), .rst(rst), .load(acc_load), .add(acc_add),
        .smp_vld(smp_vld), .smp_data(smp_data), .acc(acc)
    );

    gacc_requant #(.ACC_W(ACC_W), .DROP(DROP)) rq_i (
        .clk(clk), .rst(rst), .rnd_mode(rnd_mode), .acc(acc), .res(res_data)
    );

    a_r1_no_result_in_reset: assert property (@(posedge clk)
        rst |=> !res_vld);
endmodule

// File: tb/gacc_top_tb_top.sv
module gacc_top_tb_top;
    localparam int IN_W  = 12;
    localparam int GUARD = 4;
    localparam int DROP  = 4;
    localparam int LEN_W = 6;
    localparam int OUT_W = IN_W + GUARD - DROP;
    localparam int MAXO  = (1 << (OUT_W - 1)) - 1;
    localparam int NSAFE = 1 << GUARD;

    logic             clk = 1'b0;
    logic             rst, clr, smp_vld, rnd_mode;
    logic [IN_W-1:0]  smp_data;
    logic [LEN_W-1:0] blk_len;
    logic             res_vld, ovf;
    logic [OUT_W-1:0] res_data;

    int n_chk = 0;
    int n_err = 0;
    int smp [0:63];

    always #5 clk = ~clk;

    gacc_top #(.IN_W(IN_W), .GUARD(GUARD), .DROP(DROP), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .clr(clr), .smp_vld(smp_vld), .smp_data(smp_data),
        .blk_len(blk_len), .rnd_mode(rnd_mode), .res_vld(res_vld),
        .res_data(res_data), .ovf(ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    function automatic int wrap_acc(input int s);
        int w;
        w = s & 32'hFFFF;
        if (w >= 32768) w = w - 65536;
        return w;
    endfunction

    function automatic int ref_out(input int s, input bit rnd);
        int w, r;
        w = wrap_acc(s);
        if (!rnd) return w >>> DROP;
        r = (w + (1 << (DROP - 1))) >>> DROP;
        if (r > MAXO) r = MAXO;
        return r;
    endfunction

    function automatic int res_int();
        return int'($signed(res_data));
    endfunction

    task automatic run_block(input int len, input bit rnd, input bit first,
                             input bit gaps, input string req);
        int total = 0;
        int idx;
        @(negedge clk);
        blk_len  = LEN_W'(len);
        rnd_mode = rnd;
        clr      = 1'b1;
        smp_vld  = first;
        smp_data = first ? IN_W'(smp[0]) : '0;
        idx = 0;
        if (first) begin
            total = smp[0];
            idx = 1;
        end
        while (idx < len) begin
            @(negedge clk);
            clr = 1'b0;
            if (gaps && ($urandom % 3 == 0)) begin
                smp_vld = 1'b0;
            end else begin
                smp_vld  = 1'b1;
                smp_data = IN_W'(smp[idx]);
                total += smp[idx];
                idx++;
            end
        end
        @(negedge clk);
        clr = 1'b0;
        smp_vld = 1'b0;
        chk({req, " R5 res_vld"}, int'(res_vld), 1);
        chk({req, " result"}, res_int(), ref_out(total, rnd));
        chk({req, " R9 ovf"}, int'(ovf), int'(len > NSAFE));
        @(negedge clk);
        chk("R5 pulse ends", int'(res_vld), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; clr = 1'b0; smp_vld = 1'b0; smp_data = '0;
        blk_len = LEN_W'(1); rnd_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset res_vld", int'(res_vld), 0);
        chk("R1 reset ovf", int'(ovf), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", int'(res_vld), 0);

        // R2: mixed sign pair, -1.25 + 3.25 in 8 fraction bits -> 2.0
        smp[0] = -320; smp[1] = 832;
        run_block(2, 1'b0, 1'b1, 1'b0, "R2 R6 mixed sign");

        // R3: worst-case full runs
        for (int i = 0; i < NSAFE; i++) smp[i] = 2047;
        run_block(NSAFE, 1'b0, 1'b1, 1'b0, "R3 max run trunc");
        run_block(NSAFE, 1'b1, 1'b1, 1'b0, "R3 max run round");
        for (int i = 0; i < NSAFE; i++) smp[i] = -2048;
        run_block(NSAFE, 1'b0, 1'b1, 1'b0, "R3 min run trunc");
        run_block(NSAFE, 1'b1, 1'b0, 1'b0, "R3 R4 min run zero load");

        // R6/R7 half-LSB boundaries
        smp[0] = 8;   run_block(1, 1'b1, 1'b1, 1'b0, "R7 +half");
        smp[0] = 8;   run_block(1, 1'b0, 1'b1, 1'b0, "R6 +half trunc");
        smp[0] = 7;   run_block(1, 1'b1, 1'b1, 1'b0, "R7 below half");
        smp[0] = -8;  run_block(1, 1'b1, 1'b1, 1'b0, "R7 -half");
        smp[0] = -8;  run_block(1, 1'b0, 1'b1, 1'b0, "R6 -half floor");
        smp[0] = -9;  run_block(1, 1'b1, 1'b1, 1'b0, "R7 below -half");
        smp[0] = 5;   run_block(1, 1'b1, 1'b0, 1'b0, "R4 zero load single");

        // R8/R9: one sample beyond the guarantee, wrapped sum 32767
        for (int i = 0; i < NSAFE; i++) smp[i] = 2047;
        smp[NSAFE] = 15;
        run_block(NSAFE + 1, 1'b1, 1'b1, 1'b0, "R8 R9 saturate");
        chk("R9 ovf held in idle", int'(ovf), 1);

        // R10: samples while idle are ignored
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            smp_vld = 1'b1;
            smp_data = IN_W'(1000);
            @(negedge clk);
            smp_vld = 1'b0;
            chk("R10 no res_vld while idle", int'(res_vld), 0);
            chk("R10 ovf unchanged while idle", int'(ovf), 1);
        end
        smp[0] = 48; smp[1] = -16;
        run_block(2, 1'b0, 1'b1, 1'b0, "R9 R10 next run clean");

        // R4: clear in the middle of a run
        @(negedge clk);
        blk_len = LEN_W'(4); clr = 1'b1; smp_vld = 1'b1; smp_data = IN_W'(100);
        @(negedge clk);
        clr = 1'b0; smp_data = IN_W'(200);
        @(negedge clk);
        smp_data = IN_W'(300);
        @(negedge clk);
        smp_vld = 1'b0;
        chk("R4 partial run no result", int'(res_vld), 0);
        smp[0] = -700; smp[1] = 33; smp[2] = 411;
        run_block(3, 1'b1, 1'b1, 1'b1, "R4 restart");

        // random runs
        for (int b = 0; b < 60; b++) begin
            int len;
            len = (b % 10 == 9) ? int'($urandom_range(17, 40)) : int'($urandom_range(1, 16));
            for (int i = 0; i < len; i++) smp[i] = int'($urandom_range(0, 4095)) - 2048;
            run_block(len, 1'($urandom % 2), 1'($urandom % 2), 1'b1, "R2 R6 R7 random");
        end

        summary();
        $finish;
    end
endmodule